// File: doc/BRIEF.md
# Multiphase Clock and Time Pulse Generator

This block turns one fast master clock into the timing skeleton of a machine's memory cycle. A free-running four-step phase counter cuts every group of four master clocks into four non-overlapping phase pulses. Read-time, clear-time and write-time strobes are derived from three of those phases. Each group of four master clocks forms one time step. A one-hot ring of twelve time pulses walks through the steps, and one full pass of the ring is one memory cycle. At most one memory access is meant to fall in each memory cycle.

A level run input gates the ring. It is sampled only in the last master clock of a step, so no step is ever cut short. When the ring is stopped, all time pulses and all read/clear/write strobes are low. When it is restarted, it begins again at the first time pulse and raises a cycle-start strobe. A second, independent five-step ring advances once every two master clocks and feeds a toggle stage. This gives a slow square-wave reference at one twentieth of the master rate, for use by a downstream power-of-two scaler. With a 2.048 MHz master clock that reference is 102.4 kHz.

Top module: `mcycle_timer`

## Requirements
- R1: The output phase is one-hot at all times after reset. Bit i is high in exactly the master clocks whose count since reset release, taken modulo 4, equals i. Counting starts at 0 in the first clock after reset.
- R2: While the ring runs, rd_pulse is high in phase 1, clr_pulse in phase 2 and wr_pulse in phase 3. All three are low in phase 0 and are low at all times while the ring is stopped.
- R3: While the ring runs, tp is one-hot. Each time pulse lasts four master clocks, starting at phase 0. The ring advances from tp[0] up to tp[11] and then wraps back to tp[0].
- R4: During reset and in the first clock after it, phase is 4'b0001, tp is 12'h001, cyc_start is high and slow_ref is low. The ring comes out of reset running.
- R5: If run is low in a phase-3 clock, then from the next clock tp is all zeros. It stays all zeros until a restart.
- R6: If run is high in a phase-3 clock while the ring is stopped, then in the next clock tp is 12'h001 and cyc_start is high.
- R7: cyc_start is high exactly in phase 0 of every step in which tp[0] is asserted, and low in every other clock.
- R8: slow_ref is low for the first 10 master clocks after reset release and then toggles every 10 master clocks, giving a period of 20 master clocks. It is not affected by run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run | input | 1 | Start/stop level for the time pulse ring, sampled in phase 3 |
| phase | output | 4 | One-hot phase pulses, one master clock each |
| rd_pulse | output | 1 | Read-time strobe |
| clr_pulse | output | 1 | Clear-time strobe |
| wr_pulse | output | 1 | Write-time strobe |
| tp | output | 12 | One-hot time pulses T01..T12 (bit 0 is T01) |
| cyc_start | output | 1 | Memory-cycle start strobe, phase 0 of T01 |
| slow_ref | output | 1 | Scaler reference, master clock divided by 20 |

## Verification
The assertions assume that run is a clean synchronous level that changes only between clock edges, and that only its value in phase 3 matters. They also assume that reset is held for at least one edge. The stimulus changes run only on falling clock edges. It changes run at several different phases, including pulses shorter than a step that must be missed and stops that last a few whole steps. This lets the per-clock reference model exercise both the ignored and the honoured cases of the sampling rule.

// File: rtl/mcycle_timer.sv
module mcycle_timer #(
  parameter int STEPS    = 12,
  parameter int SUBSTEPS = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  output logic [3:0]       phase,
  output logic             rd_pulse,
  output logic             clr_pulse,
  output logic             wr_pulse,
  output logic [STEPS-1:0] tp,
  output logic             cyc_start,
  output logic             slow_ref
);

  logic [1:0]          ph_q;
  logic [STEPS-1:0]    ring_q;
  logic                act_q;
  logic [SUBSTEPS-1:0] sub_q;
  logic                slow_q;

  wire step_end = (ph_q == 2'd3);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ph_q <= 2'd0;
    else        ph_q <= ph_q + 2'd1;

  // ring steps only at step boundaries; an illegal pattern falls back to T01
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ring_q <= STEPS'(1);
      act_q  <= 1'b1;
    end else if (step_end) begin
      if (!run)
        act_q <= 1'b0;
      else if (!act_q) begin
        act_q  <= 1'b1;
        ring_q <= STEPS'(1);
      end else if ($onehot(ring_q))
        ring_q <= {ring_q[STEPS-2:0], ring_q[STEPS-1]};
      else
        ring_q <= STEPS'(1);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sub_q  <= SUBSTEPS'(1);
      slow_q <= 1'b0;
    end else if (ph_q[0]) begin
      sub_q <= {sub_q[SUBSTEPS-2:0], sub_q[SUBSTEPS-1]};
      if (sub_q[SUBSTEPS-1]) slow_q <= ~slow_q;
    end

  assign phase     = 4'b0001 << ph_q;
  assign tp        = act_q ? ring_q : '0;
  assign rd_pulse  = act_q && ph_q == 2'd1;
  assign clr_pulse = act_q && ph_q == 2'd2;
  assign wr_pulse  = act_q && ph_q == 2'd3;
  assign cyc_start = act_q && ring_q[0] && ph_q == 2'd0;
  assign slow_ref  = slow_q;

  p_phase_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    phase[3] |=> phase[0]);
  p_strobe_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pulse |-> (phase[1] && tp != '0));
  p_tp_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tp));
  p_tp_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tp != '0 && !phase[3]) |=> $stable(tp));
  p_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase[3] && !run) |=> (tp == '0 && !rd_pulse && !wr_pulse));
  p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase[3] && run && tp == '0) |=> (tp == STEPS'(1) && cyc_start));
  p_cyc_t01_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start |-> (tp[0] && phase[0]));
  p_slow_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !phase[1] && !phase[3] |=> $stable(slow_ref));

endmodule

// File: tb/tb_mcycle_timer.sv
module tb_mcycle_timer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b1;
  logic [3:0] phase;
  logic rd_pulse, clr_pulse, wr_pulse, cyc_start, slow_ref;
  logic [11:0] tp;

  mcycle_timer dut (
    .clk(clk), .rst_n(rst_n), .run(run), .phase(phase),
    .rd_pulse(rd_pulse), .clr_pulse(clr_pulse), .wr_pulse(wr_pulse),
    .tp(tp), .cyc_start(cyc_start), .slow_ref(slow_ref)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;

  // behavioural reference: integer counters since reset release
  int  mk = 0;
  int  mph = 0;
  int  mstep = 0;
  bit  mact = 1'b1;

  always @(posedge clk) begin
    if (!rst_n) begin
      mk = 0; mph = 0; mstep = 0; mact = 1'b1;
    end else begin
      if (mph == 3) begin
        if (!run) mact = 1'b0;
        else if (!mact) begin mact = 1'b1; mstep = 0; end
        else mstep = (mstep + 1) % 12;
      end
      mph = (mph + 1) % 4;
      mk  = mk + 1;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at k=%0d", tag, act, exp, mk);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    logic [11:0] etp;
    etp = mact ? (12'd1 << mstep) : 12'd0;
    chk("R1 phase", 32'(phase), 32'(4'b0001 << mph));
    chk("R2 rd_pulse",  32'(rd_pulse),  32'(mact && mph == 1));
    chk("R2 clr_pulse", 32'(clr_pulse), 32'(mact && mph == 2));
    chk("R2 wr_pulse",  32'(wr_pulse),  32'(mact && mph == 3));
    if (mact) chk("R3 tp", 32'(tp), 32'(etp));
    else      chk("R5 tp stopped", 32'(tp), 32'(etp));
    chk("R6/R7 cyc_start", 32'(cyc_start), 32'(mact && mstep == 0 && mph == 0));
    chk("R8 slow_ref", 32'(slow_ref), 32'((mk / 10) % 2));
  end

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait_n(2);
    chk("R4 reset phase", 32'(phase), 32'h1);
    chk("R4 reset tp", 32'(tp), 32'h001);
    chk("R4 reset cyc_start", 32'(cyc_start), 32'h1);
    chk("R4 reset slow_ref", 32'(slow_ref), 32'h0);
    rst_n = 1'b1;
    wait_n(3 * 48);
    run = 1'b0; wait_n(30);
    run = 1'b1; wait_n(61);
    run = 1'b0; wait_n(2);
    run = 1'b1; wait_n(50);
    run = 1'b0; wait_n(9);
    run = 1'b1; wait_n(1);
    run = 1'b0; wait_n(7);
    run = 1'b1; wait_n(100);
    for (int i = 0; i < 8; i++) begin
      run = 1'b0; wait_n(4 + i);
      run = 1'b1; wait_n(23 + 3 * i);
    end
    wait_n(48);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule